// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter

This block decides which of four DMA channels may own the transfer engine next. Each channel raises a request line. That request only counts when the channel is allowed to compete. A channel is allowed when a global master enable is set, its own enable input is set, its transfer-end flag is clear, and the shared NMI flag is clear. Among the channels that are allowed and requesting, the block registers a one-hot grant. Once a channel holds the grant, it keeps it for as long as its request and its eligibility stay asserted.

Each channel has its own select bit in a small operation register. That bit puts the channel either in a fixed group ordered by index or in a rotating group that is served round-robin. A requesting fixed channel always beats the rotating group. Inside the rotating group, the channel that follows the most recently granted rotating channel, in cyclic index order, goes first. Software reaches the register through a one-cycle write strobe and a combinational read port.

The request, grant and flag pins are plain level signals and carry no payload, so none of them uses a valid/ready handshake.

Top module: `dma_req_arbiter`

## Requirements
- R1: The operation register holds the master enable in bit 16 and the per-channel select bits in bits 5, 4, 3 and 2 for channels 0, 1, 2 and 3 respectively. A select bit of 1 means rotating and 0 means fixed. All of these bits reset to 0, are written while `reg_we` is high at a clock edge, and read back on `reg_rdata` in the same cycle.
- R2: Bits 31 to 17, 15 to 6 and 1 to 0 always read as 0, whatever was written to them.
- R3: Channel i may receive a grant only when the master enable is 1, `ch_en[i]` is 1, `ch_te[i]` is 0, `nmi_flag` is 0 and `req[i]` is 1.
- R4: While the master enable reads 0, `gnt` is all zero from the following clock edge onward.
- R5: `gnt` is a registered value. It is all zero after reset and is never more than one-hot. Bit i of `gnt` corresponds to channel i.
- R6: A granted channel keeps `gnt` unchanged as long as its request and eligibility stay high, even if a higher-priority channel starts requesting. Arbitration is repeated in the cycle after either of them drops.
- R7: With all select bits 0, the lowest-index requesting eligible channel wins.
- R8: Among rotating channels, the winner is the first requesting channel after the last-granted rotating channel in cyclic index order. After reset, channel 0 is first. The pointer moves only when a rotating channel is granted.
- R9: A requesting eligible fixed channel wins over every rotating channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Write strobe for the operation register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational readback of the operation register |
| ch_en | input | 4 | Per-channel enable bits |
| ch_te | input | 4 | Per-channel transfer-end flags |
| nmi_flag | input | 1 | Global NMI flag, blocks all channels |
| req | input | 4 | Per-channel transfer requests |
| gnt | output | 4 | Registered one-hot grant |

## Verification
Several properties are checked by assertions on every cycle:
- the grant is at most one-hot and only ever reaches a channel that was requesting and eligible at the previous edge;
- a held grant persists;
- the grant is cleared after the master enable reads 0;
- a fixed channel is chosen over the rotating group.

Other behaviours depend on sequences, and only the bench scenarios can show them. These are the exact rotation order and pointer history across mixed group settings, the readback of the register layout and its reserved bits, and the effect of each individual eligibility flag.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int unsigned ARB_NCH    = 4;
  localparam int unsigned ARB_DW     = 32;
  localparam int unsigned ARB_ME_POS = 16;
  localparam int unsigned ARB_RR_TOP = 5;
endpackage

// File: rtl/dma_arb_cfg.sv
module dma_arb_cfg #(
  parameter int unsigned NCH    = 4,
  parameter int unsigned DW     = 32,
  parameter int unsigned ME_POS = 16,
  parameter int unsigned RR_TOP = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  output logic           master_en,
  output logic [NCH-1:0] rr_sel
);
  logic unused_wbits;
  assign unused_wbits = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_en <= 1'b0;
      rr_sel    <= '0;
    end else if (we) begin
      master_en <= wdata[ME_POS];
      for (int i = 0; i < int'(NCH); i++) rr_sel[i] <= wdata[RR_TOP-i];
    end
  end

  always_comb begin
    rdata         = '0;
    rdata[ME_POS] = master_en;
    for (int i = 0; i < int'(NCH); i++) rdata[RR_TOP-i] = rr_sel[i];
  end
endmodule

// File: rtl/dma_arb_elig.sv
module dma_arb_elig #(
  parameter int unsigned NCH = 4
) (
  input  logic           master_en,
  input  logic           nmi,
  input  logic [NCH-1:0] ch_en,
  input  logic [NCH-1:0] ch_te,
  input  logic [NCH-1:0] req,
  output logic [NCH-1:0] act
);
  for (genvar g = 0; g < int'(NCH); g++) begin : g_ch
    assign act[g] = req[g] & ch_en[g] & ~ch_te[g] & master_en & ~nmi;
  end
endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick #(
  parameter int unsigned NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] act,
  input  logic [NCH-1:0] rr_sel,
  output logic [NCH-1:0] gnt
);
  localparam int unsigned IW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [NCH-1:0] ONE = NCH'(1);

  logic [IW-1:0]  ptr;
  logic [IW-1:0]  rot_idx;
  logic [NCH-1:0] fixed_c, rot_c, fix_pick, rot_pick, gnt_n;
  logic           hold, found;

  assign hold    = |(gnt & act);
  assign fixed_c = act & ~rr_sel;
  assign rot_c   = act & rr_sel;

  always_comb begin
    fix_pick = '0;
    for (int i = int'(NCH) - 1; i >= 0; i--)
      if (fixed_c[i]) fix_pick = ONE << i;
  end

  always_comb begin
    rot_pick = '0;
    rot_idx  = ptr;
    found    = 1'b0;
    for (int k = 1; k <= int'(NCH); k++) begin
      int unsigned idx;
      idx = (int'(ptr) + k) % NCH;
      if (!found && rot_c[idx]) begin
        rot_pick = ONE << idx;
        rot_idx  = IW'(idx);
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    if (hold)          gnt_n = gnt;
    else if (|fixed_c) gnt_n = fix_pick;
    else               gnt_n = rot_pick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt <= '0;
      ptr <= IW'(NCH - 1);
    end else begin
      gnt <= gnt_n;
      if (!hold && !(|fixed_c) && found) ptr <= rot_idx;
    end
  end

  // R5
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  // R5
  gnt_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0) |-> ((gnt & $past(act)) != '0));
  // R6
  gnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt & act) != '0) |=> (gnt == $past(gnt)));
  // R9
  fixed_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((gnt & act) == '0) && ((act & ~rr_sel) != '0)) |=> ((gnt & ~$past(rr_sel)) != '0));
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter #(
  parameter int unsigned NCH    = dma_arb_pkg::ARB_NCH,
  parameter int unsigned DW     = dma_arb_pkg::ARB_DW,
  parameter int unsigned ME_POS = dma_arb_pkg::ARB_ME_POS,
  parameter int unsigned RR_TOP = dma_arb_pkg::ARB_RR_TOP
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  input  logic [NCH-1:0] ch_en,
  input  logic [NCH-1:0] ch_te,
  input  logic           nmi_flag,
  input  logic [NCH-1:0] req,
  output logic [NCH-1:0] gnt
);
  logic           master_en;
  logic [NCH-1:0] rr_sel, act;

  dma_arb_cfg #(.NCH(NCH), .DW(DW), .ME_POS(ME_POS), .RR_TOP(RR_TOP)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .wdata(reg_wdata), .rdata(reg_rdata),
    .master_en(master_en), .rr_sel(rr_sel)
  );

  dma_arb_elig #(.NCH(NCH)) u_elig (
    .master_en(master_en), .nmi(nmi_flag), .ch_en(ch_en), .ch_te(ch_te),
    .req(req), .act(act)
  );

  dma_arb_pick #(.NCH(NCH)) u_pick (
    .clk(clk), .rst_n(rst_n), .act(act), .rr_sel(rr_sel), .gnt(gnt)
  );

  // R4
  me_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |=> (gnt == '0));
endmodule

// File: tb/dma_req_arbiter_bench.sv
`timescale 1ns/1ps
module dma_req_arbiter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  ch_en = 4'hF, ch_te = 4'h0, req = 4'h0, gnt;
  logic        nmi_flag = 1'b0;

  int checks = 0;
  int failures = 0;
  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  dma_req_arbiter u_dma_req_arbiter (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ch_en(ch_en), .ch_te(ch_te), .nmi_flag(nmi_flag),
    .req(req), .gnt(gnt)
  );

  // monitor: compares the grant produced by each edge with the queued item
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [3:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (gnt !== e) begin
        failures++;
        $display("FAIL %s gnt actual=%b expected=%b", t, gnt, e);
      end
    end
  end

  task automatic step(input logic [3:0] r, input logic [3:0] en, input logic [3:0] te,
                      input logic nmi, input logic [3:0] e, input string t);
    @(negedge clk);
    reg_we = 1'b0;
    req = r; ch_en = en; ch_te = te; nmi_flag = nmi;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1;
    reg_wdata = d;
  endtask

  task automatic rd_check(input logic [31:0] e, input string t);
    @(negedge clk);
    reg_we = 1'b0;
    #1;
    checks++;
    if (reg_rdata !== e) begin
      failures++;
      $display("FAIL %s rdata actual=%h expected=%h", t, reg_rdata, e);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    checks++;
    if (gnt !== 4'h0) begin
      failures++;
      $display("FAIL R5 reset gnt actual=%b expected=0000", gnt);
    end
    rd_check(32'h0, "R1 reset");
    wr(32'hFFFF_FFFF);
    rd_check(32'h0001_003C, "R2 R1 reserved");

    // R7 fixed order and R6 hold
    wr(32'h0001_0000);
    rd_check(32'h0001_0000, "R1 fixed cfg");
    step(4'b1111, 4'hF, 4'h0, 1'b0, 4'b0001, "R7");
    step(4'b1111, 4'hF, 4'h0, 1'b0, 4'b0001, "R6");
    step(4'b1110, 4'hF, 4'h0, 1'b0, 4'b0010, "R7");
    step(4'b1100, 4'hF, 4'h0, 1'b0, 4'b0100, "R7");
    step(4'b1000, 4'hF, 4'h0, 1'b0, 4'b1000, "R7");
    step(4'b0000, 4'hF, 4'h0, 1'b0, 4'b0000, "R5");
    step(4'b0100, 4'hF, 4'h0, 1'b0, 4'b0100, "R7");
    step(4'b0101, 4'hF, 4'h0, 1'b0, 4'b0100, "R6");
    step(4'b0001, 4'hF, 4'h0, 1'b0, 4'b0001, "R6");
    step(4'b0000, 4'hF, 4'h0, 1'b0, 4'b0000, "R5");

    // R8 pure rotation, pointer untouched by fixed grants
    wr(32'h0001_003C);
    step(4'b1111, 4'hF, 4'h0, 1'b0, 4'b0001, "R8");
    step(4'b1110, 4'hF, 4'h0, 1'b0, 4'b0010, "R8");
    step(4'b1101, 4'hF, 4'h0, 1'b0, 4'b0100, "R8");
    step(4'b1011, 4'hF, 4'h0, 1'b0, 4'b1000, "R8");
    step(4'b0111, 4'hF, 4'h0, 1'b0, 4'b0001, "R8");
    step(4'b0000, 4'hF, 4'h0, 1'b0, 4'b0000, "R8");

    // R9 mixed: ch1 fixed, others rotating
    wr(32'h0001_002C);
    rd_check(32'h0001_002C, "R1 mixed cfg");
    step(4'b1111, 4'hF, 4'h0, 1'b0, 4'b0010, "R9");
    step(4'b1101, 4'hF, 4'h0, 1'b0, 4'b0100, "R8");
    step(4'b1011, 4'hF, 4'h0, 1'b0, 4'b0010, "R9");
    step(4'b1001, 4'hF, 4'h0, 1'b0, 4'b1000, "R8");
    step(4'b0000, 4'hF, 4'h0, 1'b0, 4'b0000, "R8");

    // R3 eligibility flags
    wr(32'h0001_0000);
    step(4'b1111, 4'hF, 4'b0001, 1'b0, 4'b0010, "R3 te");
    step(4'b1111, 4'hF, 4'b0001, 1'b1, 4'b0000, "R3 nmi");
    step(4'b0011, 4'b1101, 4'h0, 1'b0, 4'b0001, "R3 en");
    step(4'b0010, 4'b1101, 4'h0, 1'b0, 4'b0000, "R3 en");
    step(4'b0001, 4'hF, 4'h0, 1'b0, 4'b0001, "R3");
    step(4'b0001, 4'hF, 4'b0001, 1'b0, 4'b0000, "R6 te drop");

    // R4 master enable cleared under a held grant
    step(4'b0100, 4'hF, 4'h0, 1'b0, 4'b0100, "R4 setup");
    wr(32'h0000_0000);
    step(4'b0100, 4'hF, 4'h0, 1'b0, 4'b0000, "R4");
    step(4'b1111, 4'hF, 4'h0, 1'b0, 4'b0000, "R4");
    rd_check(32'h0, "R1 cleared");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule